// File: doc/BRIEF.md
# Register-Operand Logical-AND Execute Unit

This unit executes the byte-coded logical-AND instruction family when both operands are registers or one is an immediate. Each instruction arrives as one issue beat. The beat carries an opcode byte, an operand-format byte (ModRM: mode in bits 7:6, reg field in bits 5:3, r/m field in bits 2:0), a 32-bit immediate field and an operand-size bit. The unit reads an internal file of eight 32-bit general registers. It forms the bitwise AND and writes the result to the destination. It also updates five status flags: parity, sign, zero, carry and overflow.

The unit recognises the accumulator short forms, the immediate-group forms (valid only when the reg field selects AND), and the register-to-register forms with their direction bit. Every other encoding is refused: the unit raises `unsup` and changes no register and no flag. Registers are loaded and inspected through a simple side port for initialisation and observation. An instruction completes two clocks after issue, and the cycle-count output then reports 2.

Top module: `land_exec`

## Requirements
- R1: Opcode 0x24 ANDs `imm[7:0]` into the low byte of register 0. Opcode 0x25 ANDs `imm` into register 0 at the operand size (`op32`=1: 32 bits, `op32`=0: 16 bits).
- R2: Opcodes 0x80, 0x81 and 0x83 with mode 3 and reg field 4 AND an immediate into the r/m register. The immediate is `imm[7:0]` at byte size for 0x80, and `imm` at the operand size for 0x81.
- R3: Under opcode 0x83, `imm[7:0]` is sign-extended to the operand size before the AND.
- R4: Opcodes 0x20 and 0x21 write the r/m register and use the reg-field register as source. Opcodes 0x22 and 0x23 write the reg-field register. Opcodes 0x20 and 0x22 are byte size, and 0x21 and 0x23 use the operand size.
- R5: Byte register codes 0 to 3 name bits 7:0 of registers 0 to 3. Codes 4 to 7 name bits 15:8 of registers 0 to 3.
- R6: A byte write changes only the selected byte, and a 16-bit write changes only bits 15:0. A 32-bit write replaces the whole register.
- R7: Every completed AND clears `flag_cf` and `flag_of`.
- R8: `flag_zf` is 1 when the result at the active width is zero. `flag_sf` is the top bit of the result at that width. `flag_pf` is 1 when result bits 7:0 hold an even number of ones.
- R9: An instruction accepted at a clock edge raises `done` for one cycle at the second edge after it. At that same edge `cycles` becomes 2, and `cycles` holds that value until the next completion.
- R10: A mode other than 3 under any ModRM opcode, a reg field other than 4 under 0x80, 0x81 or 0x83, or any other opcode, completes with `unsup`=1. Such an instruction leaves the registers and flags unchanged.
- R11: After reset all registers, all flags, `done`, `unsup` and `cycles` are 0, and `ready` is 1.
- R12: `ready` is 0 in the cycle after an accepted issue. A `start` seen while `ready` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| start | input | 1 | issue beat, taken when `ready` is 1 |
| opcode | input | 8 | instruction opcode byte |
| modrm | input | 8 | operand-format byte |
| imm | input | 32 | immediate field (low bits used for byte forms) |
| op32 | input | 1 | operand size: 1 = 32 bit, 0 = 16 bit |
| ld_en | input | 1 | side-port register load strobe |
| ld_sel | input | 3 | register to load |
| ld_data | input | 32 | load value |
| rd_sel | input | 3 | register to observe |
| rd_data | output | 32 | observed register, one cycle after `rd_sel` |
| ready | output | 1 | unit can take an issue beat |
| done | output | 1 | one-cycle completion pulse |
| unsup | output | 1 | completion was a refused encoding |
| cycles | output | 4 | clock count of the last completed instruction |
| flag_cf | output | 1 | carry flag |
| flag_pf | output | 1 | parity flag |
| flag_zf | output | 1 | zero flag |
| flag_sf | output | 1 | sign flag |
| flag_of | output | 1 | overflow flag |

## Verification
The first edge after issue latches the operands. The second edge writes the register, the flags, `done`, `unsup` and `cycles`, so all of these are due two edges after the issue beat. `rd_data` trails `rd_sel` by one edge. The bench's model advances at each rising edge under the same two-edge rule. The bench compares every result on the following falling edge, which is half a period after the edge that produced it. Register readback waits one full cycle after setting `rd_sel`.

// File: rtl/land_pkg.sv
package land_pkg;
  localparam int CODE_W = 3;
  localparam int NREG   = 2 ** CODE_W;

  typedef enum logic [1:0] {SZ8 = 2'd0, SZ16 = 2'd1, SZ32 = 2'd2} opsz_e;

  localparam logic [7:0] OP_RM_R8   = 8'h20;
  localparam logic [7:0] OP_RM_RW   = 8'h21;
  localparam logic [7:0] OP_R_RM8   = 8'h22;
  localparam logic [7:0] OP_R_RMW   = 8'h23;
  localparam logic [7:0] OP_ACC8    = 8'h24;
  localparam logic [7:0] OP_ACCW    = 8'h25;
  localparam logic [7:0] OP_GRP8    = 8'h80;
  localparam logic [7:0] OP_GRPW    = 8'h81;
  localparam logic [7:0] OP_GRPS    = 8'h83;
  localparam logic [2:0] GRP_AND    = 3'd4;
  localparam logic [1:0] MOD_REG    = 2'b11;

  function automatic logic [31:0] size_mask(opsz_e sz);
    case (sz)
      SZ8:     size_mask = 32'h0000_00ff;
      SZ16:    size_mask = 32'h0000_ffff;
      default: size_mask = 32'hffff_ffff;
    endcase
  endfunction
endpackage

// File: rtl/land_decode.sv
module land_decode
  import land_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [7:0]        opcode,
  input  logic [7:0]        modrm,
  input  logic [DW-1:0]     imm,
  input  logic              op32,
  output logic              bad,
  output opsz_e             sz,
  output logic [CODE_W-1:0] dst_code,
  output logic [CODE_W-1:0] src_code,
  output logic              use_imm,
  output logic [DW-1:0]     imm_val
);
  logic [1:0]        mode;
  logic [2:0]        rg;
  logic [2:0]        rm;
  logic [DW-1:0]     imm_raw;
  logic [DW-1:0]     imm_sx;

  assign mode   = modrm[7:6];
  assign rg     = modrm[5:3];
  assign rm     = modrm[2:0];
  assign imm_sx = {{(DW-8){imm[7]}}, imm[7:0]};

  always_comb begin
    bad      = 1'b0;
    sz       = op32 ? SZ32 : SZ16;
    dst_code = '0;
    src_code = '0;
    use_imm  = 1'b0;
    imm_raw  = imm;
    case (opcode)
      OP_ACC8: begin
        sz      = SZ8;
        use_imm = 1'b1;
      end
      OP_ACCW: use_imm = 1'b1;
      OP_GRP8, OP_GRPW, OP_GRPS: begin
        bad      = (mode != MOD_REG) || (rg != GRP_AND);
        dst_code = rm;
        use_imm  = 1'b1;
        if (opcode == OP_GRP8) sz = SZ8;
        if (opcode == OP_GRPS) imm_raw = imm_sx;
      end
      OP_RM_R8, OP_RM_RW: begin
        bad      = (mode != MOD_REG);
        dst_code = rm;
        src_code = rg;
        if (opcode == OP_RM_R8) sz = SZ8;
      end
      OP_R_RM8, OP_R_RMW: begin
        bad      = (mode != MOD_REG);
        dst_code = rg;
        src_code = rm;
        if (opcode == OP_R_RM8) sz = SZ8;
      end
      default: bad = 1'b1;
    endcase
    imm_val = imm_raw & DW'(size_mask(sz));
  end
endmodule

// File: rtl/land_regfile.sv
module land_regfile
  import land_pkg::*;
#(
  parameter int DW     = 32,
  parameter int NPORTS = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NPORTS-1:0][CODE_W-1:0]   rp_code,
  input  opsz_e                           rp_sz,
  output logic [NPORTS-1:0][DW-1:0]       rp_val,
  input  logic                            wr_en,
  input  logic [CODE_W-1:0]               wr_code,
  input  opsz_e                           wr_sz,
  input  logic [DW-1:0]                   wr_val,
  input  logic                            ld_en,
  input  logic [CODE_W-1:0]               ld_sel,
  input  logic [DW-1:0]                   ld_data,
  input  logic [CODE_W-1:0]               rd_sel,
  output logic [DW-1:0]                   rd_data
);
  logic [DW-1:0] regs [NREG];

  for (genvar p = 0; p < NPORTS; p++) begin : g_rp
    logic [CODE_W-1:0] byte_idx;
    assign byte_idx = {1'b0, rp_code[p][1:0]};
    always_comb begin
      case (rp_sz)
        SZ8:     rp_val[p] = rp_code[p][2] ? DW'(regs[byte_idx][15:8])
                                           : DW'(regs[byte_idx][7:0]);
        SZ16:    rp_val[p] = DW'(regs[rp_code[p]][15:0]);
        default: rp_val[p] = regs[rp_code[p]];
      endcase
    end
  end

  logic [CODE_W-1:0] wr_byte_idx;
  logic [3:0]        wr_lsb;
  assign wr_byte_idx = {1'b0, wr_code[1:0]};
  assign wr_lsb      = {wr_code[2], 3'b000};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en) begin
        case (wr_sz)
          SZ8:     regs[wr_byte_idx][wr_lsb +: 8] <= wr_val[7:0];
          SZ16:    regs[wr_code][15:0] <= wr_val[15:0];
          default: regs[wr_code] <= wr_val;
        endcase
      end else if (ld_en) begin
        regs[ld_sel] <= ld_data;
      end
      rd_data <= regs[rd_sel];
    end
  end
endmodule

// File: rtl/land_alu.sv
module land_alu
  import land_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  opsz_e         sz,
  output logic [DW-1:0] res,
  output logic          zf,
  output logic          sf,
  output logic          pf
);
  always_comb begin
    res = a & b & DW'(size_mask(sz));
    zf  = (res == '0);
    pf  = ~^res[7:0];
    case (sz)
      SZ8:     sf = res[7];
      SZ16:    sf = res[15];
      default: sf = res[DW-1];
    endcase
  end
endmodule

// File: rtl/land_exec.sv
module land_exec
  import land_pkg::*;
#(
  parameter int DW  = 32,
  parameter int CW  = 4,
  parameter int CYC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [7:0]    opcode,
  input  logic [7:0]    modrm,
  input  logic [31:0]   imm,
  input  logic          op32,
  input  logic          ld_en,
  input  logic [2:0]    ld_sel,
  input  logic [31:0]   ld_data,
  input  logic [2:0]    rd_sel,
  output logic [31:0]   rd_data,
  output logic          ready,
  output logic          done,
  output logic          unsup,
  output logic [3:0]    cycles,
  output logic          flag_cf,
  output logic          flag_pf,
  output logic          flag_zf,
  output logic          flag_sf,
  output logic          flag_of
);
  localparam int NPORTS = 2;

  logic              d_bad, d_imm;
  opsz_e             d_sz;
  logic [CODE_W-1:0] d_dst, d_src;
  logic [DW-1:0]     d_immv;
  logic [NPORTS-1:0][CODE_W-1:0] rp_code;
  logic [NPORTS-1:0][DW-1:0]     rp_val;

  logic              s_vld, s_bad;
  opsz_e             s_sz;
  logic [CODE_W-1:0] s_code;
  logic [DW-1:0]     s_a, s_b;
  logic [DW-1:0]     a_res;
  logic              a_zf, a_sf, a_pf;
  logic              accept, wr_en;
  logic [CW-1:0]     cyc_q;

  land_decode #(.DW(DW)) u_dec (
    .opcode(opcode), .modrm(modrm), .imm(imm), .op32(op32),
    .bad(d_bad), .sz(d_sz), .dst_code(d_dst), .src_code(d_src),
    .use_imm(d_imm), .imm_val(d_immv)
  );

  assign rp_code[0] = d_dst;
  assign rp_code[1] = d_src;

  land_regfile #(.DW(DW), .NPORTS(NPORTS)) u_rf (
    .clk(clk), .rst(rst), .rp_code(rp_code), .rp_sz(d_sz), .rp_val(rp_val),
    .wr_en(wr_en), .wr_code(s_code), .wr_sz(s_sz), .wr_val(a_res),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .rd_sel(rd_sel), .rd_data(rd_data)
  );

  land_alu #(.DW(DW)) u_alu (
    .a(s_a), .b(s_b), .sz(s_sz), .res(a_res), .zf(a_zf), .sf(a_sf), .pf(a_pf)
  );

  assign ready  = ~s_vld;
  assign accept = start & ready & ~rst;
  assign wr_en  = s_vld & ~s_bad;
  assign cycles = 4'(cyc_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      s_vld  <= 1'b0;
      s_bad  <= 1'b0;
      s_sz   <= SZ8;
      s_code <= '0;
      s_a    <= '0;
      s_b    <= '0;
    end else begin
      s_vld <= accept;
      if (accept) begin
        s_bad  <= d_bad;
        s_sz   <= d_sz;
        s_code <= d_dst;
        s_a    <= rp_val[0];
        s_b    <= d_imm ? d_immv : rp_val[1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      unsup   <= 1'b0;
      cyc_q   <= '0;
      flag_cf <= 1'b0;
      flag_pf <= 1'b0;
      flag_zf <= 1'b0;
      flag_sf <= 1'b0;
      flag_of <= 1'b0;
    end else begin
      done  <= s_vld;
      unsup <= s_vld & s_bad;
      if (s_vld) cyc_q <= CW'(CYC);
      if (wr_en) begin
        flag_cf <= 1'b0;
        flag_of <= 1'b0;
        flag_pf <= a_pf;
        flag_zf <= a_zf;
        flag_sf <= a_sf;
      end
    end
  end

  // R7
  cf_of_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !unsup) |-> (!flag_cf && !flag_of));

  // R9
  done_lat_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(accept, 2));

  // R9
  cyc_count_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (cycles == 4'd2));

  // R10
  unsup_flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && unsup) |-> $stable({flag_cf, flag_pf, flag_zf, flag_sf, flag_of}));

  // R12
  busy_after_issue_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> !ready);
endmodule

// File: tb/land_exec_bench.sv
`timescale 1ns/1ps
module land_exec_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0, modrm = '0;
  logic [31:0] imm = '0;
  logic        op32 = 1'b0;
  logic        ld_en = 1'b0;
  logic [2:0]  ld_sel = '0, rd_sel = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] rd_data;
  logic        ready, done, unsup;
  logic [3:0]  cycles;
  logic        flag_cf, flag_pf, flag_zf, flag_sf, flag_of;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  land_exec u_land_exec (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .modrm(modrm),
    .imm(imm), .op32(op32), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .ready(ready), .done(done),
    .unsup(unsup), .cycles(cycles), .flag_cf(flag_cf), .flag_pf(flag_pf),
    .flag_zf(flag_zf), .flag_sf(flag_sf), .flag_of(flag_of)
  );

  // behavioural model state
  logic [31:0] m_reg [8];
  logic        m_busy, m_done, m_unsup;
  logic [3:0]  m_cyc;
  logic        m_cf, m_pf, m_zf, m_sf, m_of;
  logic        p_bad;
  int          p_w, p_code;
  logic [31:0] p_res;

  function automatic logic [31:0] wmask(int w);
    return (w == 32) ? 32'hffff_ffff : ((32'h1 << w) - 1);
  endfunction

  function automatic logic [31:0] rget(int code, int w);
    if (w == 8) return (code >= 4) ? {24'h0, m_reg[code-4][15:8]} : {24'h0, m_reg[code][7:0]};
    return m_reg[code] & wmask(w);
  endfunction

  task automatic model_capture();
    int mo = modrm[7:6];
    int rg = modrm[5:3];
    int rm = modrm[2:0];
    int wide = op32 ? 32 : 16;
    logic [31:0] dv, sv;
    p_bad = 0; p_w = wide; p_code = 0; dv = 0; sv = 0;
    if (opcode == 8'h24)      begin p_w = 8; sv = imm; end
    else if (opcode == 8'h25) begin sv = imm; end
    else if (opcode == 8'h80 || opcode == 8'h81 || opcode == 8'h83) begin
      p_bad = (mo != 3) || (rg != 4);
      p_code = rm;
      if (opcode == 8'h80) p_w = 8;
      sv = (opcode == 8'h83) ? {{24{imm[7]}}, imm[7:0]} : imm;
    end else if (opcode >= 8'h20 && opcode <= 8'h23) begin
      p_bad = (mo != 3);
      if (opcode[0] == 1'b0) p_w = 8;
      p_code = opcode[1] ? rg : rm;
      sv = rget(opcode[1] ? rm : rg, p_w);
    end else p_bad = 1;
    if (!p_bad) dv = rget(p_code, p_w);
    p_res = dv & sv & wmask(p_w);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) m_reg[i] = 0;
      m_busy = 0; m_done = 0; m_unsup = 0; m_cyc = 0;
      m_cf = 0; m_pf = 0; m_zf = 0; m_sf = 0; m_of = 0;
    end else begin
      m_done = 0; m_unsup = 0;
      if (m_busy) begin
        m_busy = 0; m_done = 1; m_cyc = 2; m_unsup = p_bad;
        if (!p_bad) begin
          if (p_w == 8 && p_code >= 4) m_reg[p_code-4][15:8] = p_res[7:0];
          else if (p_w == 8) m_reg[p_code][7:0] = p_res[7:0];
          else if (p_w == 16) m_reg[p_code][15:0] = p_res[15:0];
          else m_reg[p_code] = p_res;
          m_cf = 0; m_of = 0;
          m_zf = (p_res == 0);
          m_sf = p_res[p_w-1];
          m_pf = ($countones(p_res[7:0]) % 2) == 0;
        end
      end else if (start) begin
        model_capture();
        m_busy = 1;
      end
      if (ld_en && !m_done) m_reg[ld_sel] = ld_data;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check("R9 done", {31'h0, done}, {31'h0, m_done});
      check("R9 cycles", {28'h0, cycles}, {28'h0, m_cyc});
      check("R10 unsup", {31'h0, unsup}, {31'h0, m_unsup});
      check("R7 cf_of", {30'h0, flag_cf, flag_of}, {30'h0, m_cf, m_of});
      check("R8 zf_sf_pf", {29'h0, flag_zf, flag_sf, flag_pf}, {29'h0, m_zf, m_sf, m_pf});
      check("R12 ready", {31'h0, ready}, {31'h0, !m_busy});
    end
  end

  task automatic load(int r, logic [31:0] v);
    @(negedge clk); ld_en = 1; ld_sel = 3'(r); ld_data = v;
    @(negedge clk); ld_en = 0;
  endtask

  task automatic issue(logic [7:0] op, logic [7:0] mr, logic [31:0] iv, logic w32);
    @(negedge clk); start = 1; opcode = op; modrm = mr; imm = iv; op32 = w32;
    @(negedge clk); start = 0;
    repeat (2) @(negedge clk);
  endtask

  // R5 R6: register contents seen through the side port
  task automatic readall(string tag);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); rd_sel = 3'(i);
      @(negedge clk); check(tag, rd_data, m_reg[i]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    readall("R11 reset regs");
    load(0, 32'h1234_56f3); load(1, 32'hdead_beef); load(2, 32'h8765_4321);
    load(3, 32'hffff_0f0f); load(4, 32'hcafe_f00d); load(5, 32'h0f0f_f0f0);
    load(6, 32'h8000_ffff); load(7, 32'h7fff_0001);
    readall("R5 R6 loaded");
    // R1 accumulator forms
    issue(8'h24, 8'h00, 32'h0000_007f, 1'b0);
    issue(8'h25, 8'h00, 32'hffff_8ff0, 1'b0);
    issue(8'h25, 8'h00, 32'h7fff_ffff, 1'b1);
    readall("R1 acc");
    // R2 group forms, R5 high byte code 5
    issue(8'h80, 8'hE5, 32'h0000_00f0, 1'b0);
    issue(8'h81, 8'hE2, 32'h0f0f_0f0f, 1'b1);
    issue(8'h81, 8'hE3, 32'h0000_8f00, 1'b0);
    readall("R2 group");
    // R3 sign extension
    issue(8'h83, 8'hE6, 32'h0000_0080, 1'b1);
    issue(8'h83, 8'hE7, 32'h0000_00fe, 1'b0);
    issue(8'h83, 8'hE4, 32'h0000_007f, 1'b1);
    readall("R3 sext");
    // R4 direction, R5 byte codes
    load(1, 32'h5555_aaaa); load(2, 32'hffff_ffff);
    issue(8'h20, 8'hD7, 32'h0, 1'b0);
    issue(8'h22, 8'hE1, 32'h0, 1'b0);
    issue(8'h21, 8'hCA, 32'h0, 1'b1);
    issue(8'h23, 8'hD3, 32'h0, 1'b0);
    readall("R4 dir");
    // R8 zero result, then sign/parity patterns
    issue(8'h24, 8'h00, 32'h0, 1'b0);
    load(5, 32'h8000_00c3);
    issue(8'h81, 8'hE5, 32'hffff_ffff, 1'b1);
    // R10 refusals keep flags and registers
    issue(8'h80, 8'hCD, 32'h0, 1'b0);
    issue(8'h81, 8'h25, 32'h0, 1'b1);
    issue(8'h21, 8'h0A, 32'h0, 1'b1);
    issue(8'h08, 8'hC0, 32'h0, 1'b1);
    readall("R10 unchanged");
    // R12 second start during busy is ignored
    @(negedge clk); start = 1; opcode = 8'h24; modrm = 0; imm = 32'h0f; op32 = 0;
    @(negedge clk); opcode = 8'h25; imm = 32'h0; op32 = 1;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    readall("R12 ignored");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule